// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store placed between a direct-mapped cache array and the next level of memory. It keeps only lines that the direct-mapped array has displaced. Two lines that share one direct-mapped set and are used in turn would otherwise evict each other on every access. Here the loser of each conflict lands in this buffer and is swapped straight back on the next reference. No trip to the next level is needed.

The cache controller raises a request when its direct-mapped array misses. The request carries the full line address that missed and, when the set held a valid line, the line about to be displaced. The buffer searches all entries by full line address. On a hit, the stored line is returned and the displaced line takes its slot in the same operation. On a miss, the displaced line is inserted, taking a free slot if one exists and otherwise the least recently used entry. The controller then fetches the missing line from the next level, so a buffer miss adds its one cycle to the total miss time. A dirty line pushed out of the buffer is presented on a write-back port with its address and data.

Top module: `vb_victim_buffer`

## Requirements
- R1: After reset no response and no write-back are signalled, and the buffer holds no lines, so every lookup misses.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A lookup whose address equals the full line address of a stored line returns `rsp_hit`=1 together with that line's data and dirty flag; a lookup that misses returns `rsp_hit`=0, `rsp_data`=0 and `rsp_dirty`=0.
- R4: On a hit with a displaced line offered (`evict_valid`=1), the displaced line with its data and dirty flag is stored in the buffer, and a later lookup of its address hits.
- R5: A line returned by a hit leaves the buffer: a later lookup of the same address misses unless that line has been inserted again.
- R6: On a miss with a displaced line offered, the line is inserted. While fewer than ENTRIES lines are held, nothing is pushed out and `wb_valid` stays low.
- R7: On a miss with a displaced line offered and the buffer full, the least recently used line is replaced. Recency is renewed when a line is inserted, including by a swap on a hit.
- R8: When the line replaced under R7 is dirty, `wb_valid` is high in the cycle after the request, with that line's address and data on `wb_addr`/`wb_data`. A clean replaced line, a hit, or an insertion into a free entry gives `wb_valid`=0.
- R9: While `req_valid` is low, the inputs `evict_*` and `req_addr` have no effect on the stored lines or the outputs.
- R10: A miss with no displaced line offered leaves the stored lines and the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Controller request after a direct-mapped miss |
| req_addr | input | LA_W | Full line address that missed |
| evict_valid | input | 1 | A displaced line accompanies the request |
| evict_addr | input | LA_W | Full line address of the displaced line |
| evict_data | input | LINE_W | Data of the displaced line |
| evict_dirty | input | 1 | Displaced line is modified |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_hit | output | 1 | Requested line was found |
| rsp_data | output | LINE_W | Data of the found line, zero on a miss |
| rsp_dirty | output | 1 | Dirty flag of the found line |
| wb_valid | output | 1 | A dirty line was pushed out and must be written back |
| wb_addr | output | LA_W | Line address of the write-back |
| wb_data | output | LINE_W | Data of the write-back |

## Verification
The bench drives two alternating conflicting lines through the swap path. A design that failed to place the displaced line into the hit entry would start missing on the second round. It then fills the buffer and overflows it with a mix of clean and dirty lines. Wrong LRU tracking shows as the wrong address on `wb_addr`, or a missing write-back after a recently swapped line. Lookups after a hit without a displaced line confirm the entry was freed, and a later insertion must use that free slot rather than push out a live line. Idle cycles with garbage on the `evict_*` pins must leave later lookups unchanged.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Kind of operation applied to the buffer in one request cycle
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,   // no request
        OP_SWAP = 3'd1,   // hit, displaced line replaces the found one
        OP_TAKE = 3'd2,   // hit, nothing to put back: entry freed
        OP_FILL = 3'd3,   // miss, displaced line inserted
        OP_NONE = 3'd4    // miss, nothing to insert
    } vb_op_e;

    function automatic vb_op_e vb_decode(input logic req, input logic found,
                                         input logic offer);
        vb_op_e op;
        if (!req)       op = OP_IDLE;
        else if (found) op = offer ? OP_SWAP : OP_TAKE;
        else            op = offer ? OP_FILL : OP_NONE;
        return op;
    endfunction

    function automatic logic vb_is_hit(input vb_op_e op);
        return (op == OP_SWAP) || (op == OP_TAKE);
    endfunction

    function automatic logic vb_is_write(input vb_op_e op);
        return (op == OP_SWAP) || (op == OP_FILL);
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int ENTRIES = 4,
    parameter int LA_W    = 26,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]      valid,
    input  logic [ENTRIES*LA_W-1:0] addrs,
    input  logic [LA_W-1:0]         key,
    output logic                    found,
    output logic [IDX_W-1:0]        found_idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid[g] && (addrs[g*LA_W +: LA_W] == key);
    end

    always_comb begin
        found_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) found_idx = IDX_W'(i);
        end
    end

    assign found = |eq;
endmodule

// File: rtl/vb_age.sv
module vb_age #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     touch,
    input  logic [IDX_W-1:0]         touch_idx,
    output logic [ENTRIES*IDX_W-1:0] ages
);
    // Ages form a permutation of 0..ENTRIES-1; 0 is most recent.
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] ref_age;

    assign ref_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)   age_q[i] <= '0;
                else if (age_q[i] < ref_age)  age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_out
        assign ages[g*IDX_W +: IDX_W] = age_q[g];
    end
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]       valid,
    input  logic [ENTRIES*IDX_W-1:0] ages,
    output logic [IDX_W-1:0]         slot,
    output logic                     slot_live
);
    logic have_free;

    always_comb begin
        slot      = '0;
        slot_live = 1'b1;
        have_free = 1'b0;
        // Prefer the lowest free entry
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                slot      = IDX_W'(i);
                have_free = 1'b1;
            end
        end
        if (have_free) begin
            slot_live = 1'b0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ages[i*IDX_W +: IDX_W] == IDX_W'(ENTRIES - 1)) slot = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vb_victim_buffer.sv
module vb_victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int LA_W    = 26,
    parameter int LINE_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LA_W-1:0]   req_addr,
    input  logic              evict_valid,
    input  logic [LA_W-1:0]   evict_addr,
    input  logic [LINE_W-1:0] evict_data,
    input  logic              evict_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              wb_valid,
    output logic [LA_W-1:0]   wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [LA_W-1:0]   addr;
        logic [LINE_W-1:0] data;
        logic              dirty;
    } line_t;

    line_t              line_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    logic [ENTRIES*LA_W-1:0]  addr_flat;
    logic [ENTRIES*IDX_W-1:0] age_flat;
    logic                     found;
    logic [IDX_W-1:0]         found_idx;
    logic [IDX_W-1:0]         free_idx;
    logic                     free_live;
    logic [IDX_W-1:0]         slot;
    vb_op_e                   op;
    line_t                    incoming;
    line_t                    hit_line;
    line_t                    out_line;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign addr_flat[g*LA_W +: LA_W] = line_q[g].addr;
    end

    vb_match #(.ENTRIES(ENTRIES), .LA_W(LA_W)) i_match (
        .valid     (valid_q),
        .addrs     (addr_flat),
        .key       (req_addr),
        .found     (found),
        .found_idx (found_idx)
    );

    vb_alloc #(.ENTRIES(ENTRIES)) i_alloc (
        .valid     (valid_q),
        .ages      (age_flat),
        .slot      (free_idx),
        .slot_live (free_live)
    );

    assign op       = vb_decode(req_valid, found, evict_valid);
    assign slot     = found ? found_idx : free_idx;
    assign incoming = '{addr: evict_addr, data: evict_data, dirty: evict_dirty};
    assign hit_line = line_q[found_idx];
    assign out_line = line_q[free_idx];

    vb_age #(.ENTRIES(ENTRIES)) i_age (
        .clk       (clk),
        .rst       (rst),
        .touch     (vb_is_write(op)),
        .touch_idx (slot),
        .ages      (age_flat)
    );

    // Line storage
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) line_q[i] <= '0;
        end else begin
            if (vb_is_write(op)) begin
                line_q[slot]  <= incoming;
                valid_q[slot] <= 1'b1;
            end else if (op == OP_TAKE) begin
                valid_q[slot] <= 1'b0;
            end
        end
    end

    // Response and write-back registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
            rsp_dirty <= 1'b0;
            wb_valid  <= 1'b0;
            wb_addr   <= '0;
            wb_data   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= vb_is_hit(op);
            rsp_data  <= vb_is_hit(op) ? hit_line.data : '0;
            rsp_dirty <= vb_is_hit(op) && hit_line.dirty;
            wb_valid  <= (op == OP_FILL) && free_live && out_line.dirty;
            wb_addr   <= out_line.addr;
            wb_data   <= out_line.data;
        end
    end
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               evict_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               wb_valid,
    input logic [ENTRIES-1:0] valid_q
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_hit_in_rsp_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    p_wb_needs_insert_r8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && evict_valid) |=> !wb_valid);

    p_no_wb_on_hit_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> !wb_valid);

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(valid_q));

    p_insert_grows_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && evict_valid) |=>
            ($countones(valid_q) >= $countones($past(valid_q))));

    p_no_insert_no_grow_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !evict_valid) |=>
            ($countones(valid_q) <= $countones($past(valid_q))));
endmodule

bind vb_victim_buffer vb_checker #(.ENTRIES(ENTRIES)) i_vb_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .evict_valid (evict_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .wb_valid    (wb_valid),
    .valid_q     (valid_q)
);

// File: tb/test_vb_victim_buffer.sv
`timescale 1ns/1ps
module test_vb_victim_buffer;
    localparam int N      = 4;
    localparam int LA_W   = 26;
    localparam int LINE_W = 64;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [LA_W-1:0]   req_addr;
    logic              evict_valid;
    logic [LA_W-1:0]   evict_addr;
    logic [LINE_W-1:0] evict_data;
    logic              evict_dirty;
    logic              rsp_valid, rsp_hit, rsp_dirty, wb_valid;
    logic [LINE_W-1:0] rsp_data, wb_data;
    logic [LA_W-1:0]   wb_addr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model: front of the queues is the most recently inserted line
    logic [LA_W-1:0]   m_addr [$];
    logic [LINE_W-1:0] m_data [$];
    bit                m_dirty[$];

    always #10 clk = ~clk;

    vb_victim_buffer #(.ENTRIES(N), .LA_W(LA_W), .LINE_W(LINE_W)) i_vb_victim_buffer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
        .evict_dirty(evict_dirty), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .rsp_dirty(rsp_dirty), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    function automatic int m_find(logic [LA_W-1:0] a);
        for (int i = 0; i < m_addr.size(); i++) if (m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [LINE_W-1:0] mk_data(logic [LA_W-1:0] a, int salt);
        return {32'(a) ^ 32'h5a5a_0000, 32'(salt)};
    endfunction

    // One clock cycle: drive after a falling edge, compare at the next one
    task automatic step(input string tag, input bit rq, input logic [LA_W-1:0] ra,
                        input bit ev, input logic [LA_W-1:0] ea,
                        input logic [LINE_W-1:0] ed, input bit edirty);
        bit e_rv, e_hit, e_dirty, e_wb;
        logic [LINE_W-1:0] e_data, e_wbd;
        logic [LA_W-1:0]   e_wba;
        int k;
        req_valid = rq; req_addr = ra; evict_valid = ev;
        evict_addr = ea; evict_data = ed; evict_dirty = edirty;
        e_rv = rq; e_hit = 0; e_dirty = 0; e_data = '0; e_wb = 0; e_wba = '0; e_wbd = '0;
        if (rq) begin
            k = m_find(ra);
            if (k >= 0) begin
                e_hit = 1; e_data = m_data[k]; e_dirty = m_dirty[k];
                m_addr.delete(k); m_data.delete(k); m_dirty.delete(k);
                if (ev) begin
                    m_addr.push_front(ea); m_data.push_front(ed); m_dirty.push_front(edirty);
                end
            end else if (ev) begin
                if (m_addr.size() == N) begin
                    e_wb  = m_dirty[N-1];
                    e_wba = m_addr[N-1];
                    e_wbd = m_data[N-1];
                    void'(m_addr.pop_back()); void'(m_data.pop_back()); void'(m_dirty.pop_back());
                end
                m_addr.push_front(ea); m_data.push_front(ed); m_dirty.push_front(edirty);
            end
        end
        @(negedge clk);
        vectors++;
        if (rsp_valid !== e_rv || rsp_hit !== e_hit || rsp_data !== e_data ||
            rsp_dirty !== e_dirty) begin
            errors++;
            $display("FAIL %s: rsp v/h/d/data=%0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                     tag, rsp_valid, rsp_hit, rsp_dirty, rsp_data, e_rv, e_hit, e_dirty, e_data);
        end
        if (wb_valid !== e_wb || (e_wb && (wb_addr !== e_wba || wb_data !== e_wbd))) begin
            errors++;
            $display("FAIL %s: wb v/addr/data=%0b/%h/%h expected %0b/%h/%h",
                     tag, wb_valid, wb_addr, wb_data, e_wb, e_wba, e_wbd);
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, '0, 0, '0, '0, 0);
    endtask

    task automatic look(input string tag, input logic [LA_W-1:0] a);
        step(tag, 1, a, 0, '0, '0, 0);
    endtask

    task automatic put(input string tag, input logic [LA_W-1:0] miss_a,
                       input logic [LA_W-1:0] a, input bit dirty);
        step(tag, 1, miss_a, 1, a, mk_data(a, 7), dirty);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_addr = '0; evict_valid = 0;
        evict_addr = '0; evict_data = '0; evict_dirty = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet outputs and an empty buffer after reset
        idle("R1");
        look("R1", 26'h100);
        // R9: garbage on evict pins without a request is ignored
        step("R9", 0, 26'h200, 1, 26'h200, 64'hdead, 1);
        look("R9", 26'h200);
        // R6: fill free entries, no write-back
        put("R6", 26'h900, 26'h0A0, 1);
        put("R6", 26'h901, 26'h0B0, 0);
        // R3/R4: ping-pong between two lines sharing one set
        for (int i = 0; i < 4; i++) begin
            put("R4", 26'h0A0, 26'h0C0, 1'(i));
            put("R4", 26'h0C0, 26'h0A0, 1);
        end
        look("R3", 26'h0B0);           // hit, entry freed
        look("R5", 26'h0B0);           // must miss now
        // R10: miss with nothing to insert changes nothing
        look("R10", 26'h777);
        // R2: response spacing around idle cycles
        idle("R2"); look("R2", 26'h0A0); idle("R2");
        // R7/R8: fill and overflow with clean and dirty lines
        put("R7", 26'h902, 26'h111, 1);
        put("R7", 26'h903, 26'h222, 0);
        put("R7", 26'h904, 26'h333, 1);
        put("R7", 26'h905, 26'h444, 0);
        put("R8", 26'h906, 26'h555, 0);
        put("R8", 26'h907, 26'h666, 0);
        put("R7", 26'h333, 26'h777, 1); // swap renews recency
        put("R8", 26'h908, 26'h888, 1);
        put("R8", 26'h909, 26'h999, 1);
        put("R8", 26'h90A, 26'hAAA, 0);
        // Randomised mix over a small address pool
        for (int n = 0; n < 3000; n++) begin
            logic [LA_W-1:0] ra, ea;
            bit rq, ev;
            rq = ($urandom_range(0, 4) != 0);
            ra = LA_W'($urandom_range(0, 11));
            ea = LA_W'($urandom_range(0, 11));
            ev = ($urandom_range(0, 3) != 0) && ea != ra && m_find(ea) < 0;
            if (!rq) ev = $urandom_range(0, 1) != 0;
            step("R7", rq, ra, ev, ea, mk_data(ea, n), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule